// File: doc/BRIEF.md
# Reconfigurable Four-Neighbour Lookup Cell

This block is one cell of a clockless cellular automaton grid. It takes one bit from each of its four neighbours (north, south, east, west) and drives one bit back toward each of them. Each of the four outputs is an arbitrary Boolean function of all four inputs, chosen by its own 16-entry truth table. No clocked element sits on the path from the neighbour inputs to the outputs, so an output follows its inputs as soon as the gates settle.

The four truth tables hold 64 configuration bits in all. These bits are loaded through a serial shift chain that passes through every cell of the grid. The chain is double-buffered. Shifting only moves data through the chain flops. A bank of shadow latches holds the configuration that the tables actually use, and it takes a new copy only while the hold control is low. Because of this, a complete reprogramming pass can run without disturbing the live automaton. The shift clock passes straight through the cell to clock the next cell in the chain.

The block has no state machine. The chain and the latches are its only state. The reset state is an all-zero chain and all-zero latches. From there, two things move the block: a rising edge of the shift clock, which shifts the chain by one place, and a low hold level, which makes the latches copy the chain.

Top module: `lut_cell`

## Requirements
- R1: While reset is high, and afterwards until the first low hold pulse, every neighbour output is 0 for all 16 input combinations, and the serial output is 0.
- R2: On each rising edge of the shift clock, every chain bit moves one place toward the serial output. The serial input enters at chain bit 0, and the serial output shows chain bit 63. A 64-bit word is therefore loaded most-significant bit first.
- R3: While hold is low, the shadow latches copy the chain. Chain bits [15:0] configure the north output, [31:16] the south output, [47:32] the east output and [63:48] the west output.
- R4: Each output equals the entry of its own 16-bit table selected by the index {north, south, east, west}, with north as the most significant index bit.
- R5: While hold stays high, shifting any number of bits through the chain leaves every neighbour output unchanged.
- R6: The forwarded shift clock output always equals the shift clock input.
- R7: A change on a neighbour input reaches the outputs with no shift clock edge and no hold pulse.
- R8: After hold returns high, the latched configuration keeps driving the outputs until the next low hold pulse, even if reset of the chain is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Asynchronous reset, active high; clears chain and latches |
| sclk_i | input | 1 | Shift clock for the configuration chain |
| sclk_o | output | 1 | Shift clock forwarded to the next cell |
| sdi_i | input | 1 | Serial configuration data in |
| sdo_o | output | 1 | Serial configuration data out (chain bit 63) |
| hold_i | input | 1 | Shadow latch control; low = latches transparent |
| n_i | input | 1 | Bit from the north neighbour |
| s_i | input | 1 | Bit from the south neighbour |
| e_i | input | 1 | Bit from the east neighbour |
| w_i | input | 1 | Bit from the west neighbour |
| n_o | output | 1 | Bit to the north neighbour |
| s_o | output | 1 | Bit to the south neighbour |
| e_o | output | 1 | Bit to the east neighbour |
| w_o | output | 1 | Bit to the west neighbour |

## Verification
Every configuration word is checked over all 16 input combinations. The words used are all zeros, all ones, a mixed word in which the four tables hold four different functions (AND, OR, parity, and pass-north), and an irregular hexadecimal pattern. The mixed word shows whether the 16-bit fields are assigned to the right outputs and whether the index bits are in the right order. Both would be invisible with the uniform words. The irregular word shows whether any single table entry is swapped or shifted. A second word is then shifted through behind a loaded one while hold stays high. This checks that the outputs stay put, and that the old word appears at the serial output most-significant bit first. This separates a correct double buffer from a chain that drives the tables directly.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
    localparam int NB_SEL = 4;               // neighbour inputs per cell
    localparam int NB_OUT = 4;               // neighbour outputs per cell
    localparam int TBL_W  = 1 << NB_SEL;     // entries per truth table
    localparam int CFG_W  = NB_OUT * TBL_W;  // configuration bits per cell

    typedef enum logic [1:0] {
        DIR_NORTH = 2'd0,
        DIR_SOUTH = 2'd1,
        DIR_EAST  = 2'd2,
        DIR_WEST  = 2'd3
    } dir_e;
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
    parameter int WIDTH = 64
) (
    input  logic             rst_i,
    input  logic             sclk_i,
    input  logic             sdi_i,
    output logic [WIDTH-1:0] chain_o,
    output logic             sdo_o
);
    logic [WIDTH-1:0] chain_q;

    always_ff @(posedge sclk_i or posedge rst_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[WIDTH-2:0], sdi_i};
        end
    end

    assign chain_o = chain_q;
    assign sdo_o   = chain_q[WIDTH-1];

    AST_SHIFT_ENTRY: assert property (@(posedge sclk_i) disable iff (rst_i)
        1'b1 |=> chain_q[0] == $past(sdi_i)) else $error("serial entry"); // R2

    AST_SHIFT_ADVANCE: assert property (@(posedge sclk_i) disable iff (rst_i)
        1'b1 |=> chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0])) else $error("chain advance"); // R2
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
    parameter int WIDTH = 64
) (
    input  logic             rst_i,
    input  logic             hold_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] shadow_q;

    always_latch begin
        if (rst_i) begin
            shadow_q = '0;
        end else if (!hold_i) begin
            shadow_q = d_i;
        end
    end

    assign q_o = shadow_q;

    AST_CAPTURE: assert property (@(posedge hold_i) disable iff (rst_i)
        1'b1 |-> shadow_q == d_i) else $error("shadow capture"); // R3
endmodule

// File: rtl/lut_slice.sv
module lut_slice #(
    parameter int SEL_W = 4
) (
    input  logic [(1<<SEL_W)-1:0] table_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic                  y_o
);
    always_comb begin
        y_o = table_i[sel_i];
    end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic rst_i,
    input  logic sclk_i,
    output logic sclk_o,
    input  logic sdi_i,
    output logic sdo_o,
    input  logic hold_i,
    input  logic n_i,
    input  logic s_i,
    input  logic e_i,
    input  logic w_i,
    output logic n_o,
    output logic s_o,
    output logic e_o,
    output logic w_o
);
    logic [CFG_W-1:0]  chain_w;
    logic [CFG_W-1:0]  live_cfg;
    logic [NB_SEL-1:0] sel_w;
    logic [NB_OUT-1:0] y_w;

    assign sclk_o = sclk_i;
    assign sel_w  = {n_i, s_i, e_i, w_i};

    cfg_chain #(.WIDTH(CFG_W)) u_chain (
        .rst_i  (rst_i),
        .sclk_i (sclk_i),
        .sdi_i  (sdi_i),
        .chain_o(chain_w),
        .sdo_o  (sdo_o)
    );

    cfg_shadow #(.WIDTH(CFG_W)) u_shadow (
        .rst_i (rst_i),
        .hold_i(hold_i),
        .d_i   (chain_w),
        .q_o   (live_cfg)
    );

    for (genvar k = 0; k < NB_OUT; k++) begin : g_lut
        lut_slice #(.SEL_W(NB_SEL)) u_lut (
            .table_i(live_cfg[k*TBL_W +: TBL_W]),
            .sel_i  (sel_w),
            .y_o    (y_w[k])
        );

        AST_LUT_MATCH: assert property (@(posedge sclk_i) disable iff (rst_i)
            1'b1 |-> y_w[k] == live_cfg[k*TBL_W + int'(sel_w)]) else $error("table lookup"); // R4
    end

    assign n_o = y_w[DIR_NORTH];
    assign s_o = y_w[DIR_SOUTH];
    assign e_o = y_w[DIR_EAST];
    assign w_o = y_w[DIR_WEST];
endmodule

// File: tb/lut_cell_tb.sv
module lut_cell_tb;
    localparam int NVEC = 4;
    localparam logic [63:0] CFG_TAB [NVEC] = '{
        64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hFF00_6996_FFFE_8000,
        64'h0123_4567_89AB_CDEF
    };

    logic clk = 1'b0;
    logic rst, sclk, sdi, hold, n, s, e, w;
    logic sclk_f, sdo, no, so, eo, wo;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #5 clk = ~clk;

    lut_cell u_dut (
        .rst_i(rst), .sclk_i(sclk), .sclk_o(sclk_f), .sdi_i(sdi), .sdo_o(sdo),
        .hold_i(hold), .n_i(n), .s_i(s), .e_i(e), .w_i(w),
        .n_o(no), .s_o(so), .e_o(eo), .w_o(wo)
    );

    function automatic logic [3:0] expect_out(input logic [63:0] cfg, input int idx);
        return {cfg[idx], cfg[16+idx], cfg[32+idx], cfg[48+idx]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_in(input int idx);
        @(negedge clk);
        {n, s, e, w} = 4'(idx);
        #1;
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); sdi = b;
        @(negedge clk); sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic load_word(input logic [63:0] word);
        for (int i = 63; i >= 0; i--) shift_bit(word[i]);
    endtask

    task automatic pulse_hold();
        @(negedge clk); hold = 1'b0;
        @(negedge clk); hold = 1'b1;
        @(negedge clk);
    endtask

    task automatic sweep(input string req, input logic [63:0] cfg);
        for (int idx = 0; idx < 16; idx++) begin
            set_in(idx);
            check(req, 64'({no, so, eo, wo}), 64'(expect_out(cfg, idx)));
        end
    endtask

    initial begin
        rst = 1'b1; sclk = 1'b0; sdi = 1'b0; hold = 1'b1;
        {n, s, e, w} = 4'h0;
        repeat (3) @(negedge clk);
        // R1: outputs and serial out are zero while reset is held
        sweep("R1", 64'h0);
        check("R1 sdo", 64'(sdo), 64'h0);
        @(negedge clk); rst = 1'b0;
        sweep("R1", 64'h0);

        // R3 R4: table-driven walk over configuration words
        for (int v = 0; v < NVEC; v++) begin
            load_word(CFG_TAB[v]);
            pulse_hold();
            sweep("R4", CFG_TAB[v]);
        end

        // R2 R5: shift a new word behind the loaded one with hold high
        load_word(CFG_TAB[2]);
        pulse_hold();
        set_in(4'b1010);
        for (int i = 63; i >= 0; i--) begin
            check("R2 sdo", 64'(sdo), 64'(CFG_TAB[2][i]));
            shift_bit(CFG_TAB[3][i]);
            check("R5", 64'({no, so, eo, wo}), 64'(expect_out(CFG_TAB[2], 10)));
        end
        // R8: hold still high, latched word keeps driving outputs
        sweep("R8", CFG_TAB[2]);
        // R3: next hold pulse adopts the shifted word
        pulse_hold();
        sweep("R3", CFG_TAB[3]);

        // R7: input change alone changes outputs
        set_in(0);
        check("R7", 64'({no, so, eo, wo}), 64'(expect_out(CFG_TAB[3], 0)));
        set_in(15);
        check("R7", 64'({no, so, eo, wo}), 64'(expect_out(CFG_TAB[3], 15)));

        // R6: shift clock forwarded
        @(negedge clk); sclk = 1'b1; #1;
        check("R6", 64'(sclk_f), 64'h1);
        @(negedge clk); sclk = 1'b0; #1;
        check("R6", 64'(sclk_f), 64'h0);

        // R1: reset mid-operation clears latches and chain
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        sweep("R1", 64'h0);
        check("R1 sdo", 64'(sdo), 64'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule